// File: doc/BRIEF.md
# Clock Configuration Register Slave

This block is a two-wire serial slave that gives a host access to the eight configuration bytes of a clock generator. It sits behind open-drain pads and samples SCL and SDA with the fast system clock. The parallel register contents go straight to the clock logic. Each byte holds per-output enables, spread selects, frequency selects, spread profile bits and a feedback divider value.

A command byte follows the address. When its top bit is set, the access is indexed: the lower seven bits name a single register. When the top bit is clear, the access is a counted block transfer that starts at register 0 and walks upward. A block write carries a count from the master. A block read answers with a count before the data. Two strap inputs pick one of four adjacent slave addresses.

The controller has twelve states:
- ST_IDLE waits for a start.
- ST_ADDR, ST_CMD, ST_COUNT and ST_WDATA each receive one byte.
- ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK and ST_WDATA_ACK each pull SDA low for one acknowledge slot.
- ST_RDATA shifts a byte out.
- ST_RACK samples the master's acknowledge.
- ST_HOLD ignores the bus until the next start or stop.

A start from any state enters ST_ADDR, and a stop from any state enters ST_IDLE. The other transitions are:
- ST_ADDR moves to ST_ADDR_ACK when the address matches and to ST_IDLE when it does not.
- ST_ADDR_ACK moves to ST_RDATA for a read and to ST_CMD for a write.
- ST_CMD moves to ST_CMD_ACK.
- ST_CMD_ACK moves to ST_COUNT in block mode and to ST_WDATA in byte mode.
- ST_COUNT moves to ST_COUNT_ACK, which moves to ST_WDATA.
- ST_WDATA moves to ST_WDATA_ACK.
- ST_WDATA_ACK returns to ST_WDATA in block mode and goes to ST_HOLD in byte mode.
- ST_RDATA moves to ST_RACK.
- ST_RACK moves back to ST_RDATA on an acknowledge and to ST_HOLD on a not-acknowledge.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset the register bytes are 0:FFh, 1:FFh, 2:04h, 3 to 6:00h and 7:95h, with byte i on cfg_bytes[8i+7:8i].
- R2: The slave acknowledges the 7-bit address 68h plus addr_sel (write address D0h, D2h, D4h or D6h) by pulling SDA low in the ninth bit.
- R3: Any other address is not acknowledged, and every later byte up to the next start is ignored and not acknowledged.
- R4: A write whose command byte has bit 7 = 1 stores the next data byte into the register named by command bits 6:0.
- R5: A byte read (indexed command, repeated start, address with R/W = 1) returns that register most significant bit first.
- R6: A block write (command 00h) takes a count byte, then stores data bytes into registers 0, 1, 2 and so on in order, acknowledging each byte.
- R7: In a block write, bytes past register 7 or past the given count are acknowledged and discarded.
- R8: A block read (command 00h, repeated start, address with R/W = 1) sends the count 08h first, then registers 0 upward.
- R9: Indexed accesses to offsets 8 to 127 are acknowledged; writes there change nothing and reads return 00h.
- R10: A stop after any complete byte ends the transfer and keeps the bytes already written.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: After an indexed write, any further data byte is not acknowledged and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 2 | Address straps, added to 68h |
| sda_drive_low | output | 1 | Enable for the open-drain SDA pull-down |
| cfg_bytes | output | NUM_REGS*8 | Register file contents, byte i in bits 8i+7:8i |

## Verification
A corrupted register or pointer appears on cfg_bytes one system clock after the faulty acknowledge edge. The bench compares cfg_bytes against its model on every clock while the bus is idle. A wrong state or bit count shows first as a missing or misplaced acknowledge in the ninth bit. It can also show as a read byte that is shifted or taken from the wrong register. Either fault is caught within the same byte. Drive glitches while SCL is high are caught on the clock they occur.

// File: rtl/cfgsl_pkg.sv
`timescale 1ns/1ps
package cfgsl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } state_t;

    // power-up value of each configuration byte
    function automatic logic [7:0] reg_default(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            0, 1:    v = 8'hFF;
            2:       v = 8'h04;
            7:       v = 8'h95;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgsl_line_sync.sv
`timescale 1ns/1ps
module cfgsl_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= {STAGES{RESET_VAL}};
            prev <= RESET_VAL;
        end else begin
            sh   <= {sh[STAGES-2:0], d};
            prev <= sh[STAGES-1];
        end
    end

    assign q    = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~prev;
    assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/cfgsl_regfile.sv
`timescale 1ns/1ps
module cfgsl_regfile #(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS*8-1:0] store;
    logic                  wr_hit;
    logic                  rd_hit;

    assign wr_hit = wr_en && (wr_addr < 8'(NUM_REGS));
    assign rd_hit = rd_addr < 8'(NUM_REGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                store[i*8 +: 8] <= cfgsl_pkg::reg_default(i);
        end else if (wr_hit) begin
            store[wr_addr[IDXW-1:0]*8 +: 8] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_hit)
            rd_data = store[rd_addr[IDXW-1:0]*8 +: 8];
    end

    assign cfg_flat = store;
endmodule

// File: rtl/cfgsl_fsm.sv
`timescale 1ns/1ps
module cfgsl_fsm
    import cfgsl_pkg::*;
#(
    parameter logic [7:0] BYTE_COUNT = 8'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_q,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_q,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output state_t     state_o
);
    state_t     st, nxt;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic [7:0] remain;
    logic       blk_q;
    logic       rw_q;

    logic start_ev, stop_ev, byte_done, addr_hit;
    logic [7:0] ptr_inc;

    assign start_ev  = scl_q & sda_fall;
    assign stop_ev   = scl_q & sda_rise;
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == dev_addr);
    assign ptr_inc   = (ptr == 8'hFF) ? ptr : ptr + 8'd1;

    // next-state logic
    always_comb begin
        nxt = st;
        if (start_ev)
            nxt = ST_ADDR;
        else if (stop_ev)
            nxt = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE, ST_HOLD: nxt = st;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall)  nxt = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall)  nxt = blk_q ? ST_COUNT : ST_WDATA;
                ST_COUNT:     if (byte_done) nxt = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = blk_q ? ST_WDATA : ST_HOLD;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) nxt = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_q) nxt = ST_HOLD;
                    else if (scl_fall)     nxt = ST_RDATA;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= 8'hFF;
            ptr     <= '0;
            remain  <= '0;
            blk_q   <= 1'b0;
            rw_q    <= 1'b0;
        end else if (start_ev) begin
            bit_cnt <= '0;
        end else begin
            case (st)
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_q};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        case (st)
                            ST_ADDR:  rw_q <= shreg[0];
                            ST_CMD: begin
                                blk_q <= ~shreg[7];
                                ptr   <= shreg[7] ? {1'b0, shreg[6:0]} : 8'd0;
                            end
                            ST_COUNT: remain <= shreg;
                            default: begin
                                ptr <= ptr_inc;
                                if (blk_q && remain != 8'd0)
                                    remain <= remain - 8'd1;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            if (blk_q) begin
                                tx <= BYTE_COUNT;
                            end else begin
                                tx  <= rd_data;
                                ptr <= ptr_inc;
                            end
                        end
                    end
                end
                ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx      <= {tx[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        tx      <= rd_data;
                        ptr     <= ptr_inc;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = (st == ST_WDATA) && byte_done && (!blk_q || remain != 8'd0);
        wr_addr = ptr;
        wr_data = shreg;
        rd_addr = ptr;
        unique case (st)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    assign state_o = st;
endmodule

// File: rtl/cfg_smbus_slave.sv
`timescale 1ns/1ps
module cfg_smbus_slave #(
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = 7'h68
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [1:0]            addr_sel,
    output logic                  sda_drive_low,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);
    localparam logic [7:0] BYTE_COUNT = 8'(NUM_REGS);

    logic               scl_q, scl_rise, scl_fall;
    logic               sda_q, sda_rise, sda_fall;
    logic [6:0]         dev_addr;
    logic [7:0]         rd_addr, rd_data, wr_addr, wr_data;
    logic               wr_en;
    cfgsl_pkg::state_t  fsm_state;

    assign dev_addr = ADDR_BASE | {5'd0, addr_sel};

    cfgsl_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i),
        .q(scl_q), .rise(scl_rise), .fall(scl_fall)
    );

    cfgsl_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i),
        .q(sda_q), .rise(sda_rise), .fall(sda_fall)
    );

    cfgsl_fsm #(.BYTE_COUNT(BYTE_COUNT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_q(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .dev_addr(dev_addr), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sda_oe(sda_drive_low), .state_o(fsm_state)
    );

    cfgsl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_bytes)
    );
endmodule

// File: rtl/cfgsl_chk.sv
`timescale 1ns/1ps
module cfgsl_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_q,
    input logic                  sda_drive_low,
    input logic [NUM_REGS*8-1:0] cfg_bytes,
    input cfgsl_pkg::state_t     state,
    input logic                  wr_en,
    input logic [7:0]            wr_addr
);
    logic [NUM_REGS*8-1:0] def_flat;
    logic                  was_rst;

    always_comb
        for (int i = 0; i < NUM_REGS; i++)
            def_flat[i*8 +: 8] = cfgsl_pkg::reg_default(i);

    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> cfg_bytes == def_flat);

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == cfgsl_pkg::ST_IDLE |-> !sda_drive_low);

    // R11
    drive_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_q && $past(scl_q) |-> $stable(sda_drive_low));

    // R9
    high_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr >= 8'(NUM_REGS) |=> $stable(cfg_bytes));
endmodule

bind cfg_smbus_slave cfgsl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_drive_low(sda_drive_low),
    .cfg_bytes(cfg_bytes), .state(fsm_state), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tb_cfg_smbus_slave.sv
`timescale 1ns/1ps
module tb_cfg_smbus_slave;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b00;
    logic        sda_drive_low;
    logic [63:0] cfg_bytes;
    wire         sda = sda_m & ~sda_drive_low;

    int    vectors = 0;
    int    fails = 0;
    int    hi_changes = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string cur_req = "R1";
    logic [7:0] model [8];
    logic  oe_prev = 1'b0;
    logic  scl_prev = 1'b1;

    always #2.5 clk = ~clk;

    cfg_smbus_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .addr_sel(addr_sel), .sda_drive_low(sda_drive_low), .cfg_bytes(cfg_bytes)
    );

    // per-clock comparison against the behavioural register model
    always @(negedge clk) begin
        if (cmp_en) begin
            vectors++;
            for (int i = 0; i < 8; i++)
                if (cfg_bytes[i*8 +: 8] !== model[i]) begin
                    fails++;
                    $display("FAIL %s reg%0d actual %h expected %h", cur_req, i, cfg_bytes[i*8 +: 8], model[i]);
                end
        end
        if (rst_n && scl && scl_prev && sda_drive_low !== oe_prev) hi_changes++;
        oe_prev  = sda_drive_low;
        scl_prev = scl;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        cmp_en = 0;
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
        repeat (10) @(negedge clk);
        cmp_en = 1;
        repeat (20) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = (sda == 1'b0);
        wq(); scl = 1'b0; wq();
    endtask

    task automatic recv(input bit ack_m, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl = 1'b1; wq();
            b = {b[6:0], sda};
            wq(); scl = 1'b0; wq();
        end
        sda_m = ack_m ? 1'b0 : 1'b1;
        wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        sda_m = 1'b1; wq();
    endtask

    task automatic byte_read(input logic [7:0] wa, input logic [6:0] off, input logic [7:0] exp, input string req);
        bit ak;
        logic [7:0] d;
        bus_start();
        send(wa, ak);             chk(req, ak, 1);
        send({1'b1, off}, ak);    chk(req, ak, 1);
        bus_rstart();
        send(wa | 8'h01, ak);     chk(req, ak, 1);
        recv(0, d);
        bus_stop();
        chk(req, d, exp);
    endtask

    initial begin
        bit ak;
        logic [7:0] d;
        model[0] = 8'hFF; model[1] = 8'hFF; model[2] = 8'h04;
        model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
        model[6] = 8'h00; model[7] = 8'h95;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the outputs
        chk("R1", cfg_bytes, 64'h9500_0000_0004_FFFF);
        cmp_en = 1;
        repeat (20) @(negedge clk);

        // R2 R4: indexed write of register 2 at address D0h
        cur_req = "R4";
        bus_start();
        send(8'hD0, ak); chk("R2", ak, 1);
        send(8'h82, ak); chk("R4", ak, 1);
        send(8'hA5, ak); chk("R4", ak, 1);
        model[2] = 8'hA5;
        bus_stop();

        // R5: indexed reads, MSB first
        cur_req = "R5";
        byte_read(8'hD0, 7'd2, 8'hA5, "R5");
        byte_read(8'hD0, 7'd7, 8'h95, "R5");

        // R3: wrong address, following bytes ignored
        cur_req = "R3";
        bus_start();
        send(8'hD2, ak); chk("R3", ak, 0);
        send(8'h83, ak); chk("R3", ak, 0);
        send(8'h5A, ak); chk("R3", ak, 0);
        bus_stop();

        // R2: strap change moves the address
        cur_req = "R2";
        addr_sel = 2'b11;
        bus_start();
        send(8'hD0, ak); chk("R2", ak, 0);
        bus_stop();
        bus_start();
        send(8'hD6, ak); chk("R2", ak, 1);
        send(8'h85, ak); chk("R2", ak, 1);
        send(8'h3C, ak); chk("R2", ak, 1);
        model[5] = 8'h3C;
        bus_stop();

        // R12: second byte after an indexed write
        cur_req = "R12";
        bus_start();
        send(8'hD6, ak); chk("R12", ak, 1);
        send(8'h86, ak); chk("R12", ak, 1);
        send(8'h42, ak); chk("R12", ak, 1);
        model[6] = 8'h42;
        send(8'h99, ak); chk("R12", ak, 0);
        bus_stop();

        // R6: short block write
        cur_req = "R6";
        bus_start();
        send(8'hD6, ak); chk("R6", ak, 1);
        send(8'h00, ak); chk("R6", ak, 1);
        send(8'h03, ak); chk("R6", ak, 1);
        for (int i = 0; i < 3; i++) begin
            send(8'(8'h11 * (i + 1)), ak); chk("R6", ak, 1);
            model[i] = 8'(8'h11 * (i + 1));
        end
        bus_stop();

        // R7: count of 10, extra bytes acked and dropped
        cur_req = "R7";
        bus_start();
        send(8'hD6, ak); send(8'h00, ak); send(8'd10, ak); chk("R7", ak, 1);
        for (int i = 0; i < 10; i++) begin
            send(8'(8'hC0 + i), ak); chk("R7", ak, 1);
            if (i < 8) model[i] = 8'(8'hC0 + i);
        end
        bus_stop();
        // R7: bytes beyond a count of 1 dropped
        bus_start();
        send(8'hD6, ak); send(8'h00, ak); send(8'd1, ak);
        send(8'h0F, ak); chk("R7", ak, 1);
        send(8'hF0, ak); chk("R7", ak, 1);
        model[0] = 8'h0F;
        bus_stop();

        // R8: block read with leading count
        cur_req = "R8";
        bus_start();
        send(8'hD6, ak); chk("R8", ak, 1);
        send(8'h00, ak); chk("R8", ak, 1);
        bus_rstart();
        send(8'hD7, ak); chk("R8", ak, 1);
        recv(1, d); chk("R8", d, 8'h08);
        for (int i = 0; i < 8; i++) begin
            recv(i < 7, d); chk("R8", d, model[i]);
        end
        bus_stop();

        // R9: offsets above the file
        cur_req = "R9";
        bus_start();
        send(8'hD6, ak); chk("R9", ak, 1);
        send(8'hC0, ak); chk("R9", ak, 1);
        send(8'h77, ak); chk("R9", ak, 1);
        bus_stop();
        byte_read(8'hD6, 7'h7F, 8'h00, "R9");
        byte_read(8'hD6, 7'h08, 8'h00, "R9");

        // R10: stop part way through a block write
        cur_req = "R10";
        bus_start();
        send(8'hD6, ak); send(8'h00, ak); send(8'd8, ak);
        send(8'h5A, ak); chk("R10", ak, 1);
        send(8'h6B, ak); chk("R10", ak, 1);
        model[0] = 8'h5A; model[1] = 8'h6B;
        bus_stop();
        byte_read(8'hD6, 7'd2, model[2], "R10");

        // R11: drive changes seen while SCL was high
        chk("R11", hi_changes, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule